// File: doc/BRIEF.md
# Interleaved Multi-Channel Hit Finder with Zero Suppression

This block sits behind the filtering stage of a multi-channel waveform recorder. It takes one filtered 10-bit sample per clock. Each sample carries a 4-bit tag that names one of 16 time-interleaved channels. For every channel the block keeps a small state: a hit bit and a window down-counter. It uses that state to decide whether the sample belongs to a pulse. A pulse opens when a sample rises above a programmable high threshold. It stays open while samples remain at or above a programmable low threshold, so the two thresholds form a hysteresis band. When the pulse closes, a programmable tail of up to 15 further samples of that channel is still forwarded.

Samples that belong to no pulse and no tail are dropped. The output slot for a dropped sample carries a low valid strobe. Every forwarded sample leaves on one output stream in the same order as it arrived. It carries its channel tag, its value and a flag that marks samples inside the pulse proper. The state store is organised as four groups of four channels, and the channel tag selects the entry. A sample for any channel may follow a sample for any other channel, or for the same channel, in back-to-back cycles.

Top module: `hf_top`

## Requirements
- R1: After reset every channel is idle with an empty window, and `out_valid` is low.
- R2: The result for an input presented in cycle n appears at the outputs in cycle n+4. A forwarded word carries the unchanged channel tag and sample value.
- R3: On an idle channel, a sample strictly greater than `thr_high` opens a pulse and is forwarded with `out_hit`=1. A sample equal to `thr_high` does not open a pulse.
- R4: While a pulse is open, a sample greater than or equal to the effective low threshold keeps it open and is forwarded with `out_hit`=1.
- R5: While a pulse is open, a sample below the effective low threshold closes it. That sample is forwarded with `out_hit`=0 and loads the channel's window counter with `win_len`.
- R6: After a pulse closes, the next `win_len` valid samples of that channel are forwarded with `out_hit`=0, and later samples are dropped. With `win_len`=0 only the closing sample is forwarded.
- R7: A sample above `thr_high` during a tail reopens the pulse (`out_hit`=1). The tail is reloaded to the full `win_len` at the next close.
- R8: Channels are independent. Samples of one channel never change the state or the output of another.
- R9: When `thr_low` is programmed above `thr_high`, the effective low threshold is `thr_high`. Otherwise it is `thr_low`.
- R10: A cycle with `in_valid` low produces no output word and leaves every channel's state unchanged, whatever the tag and sample inputs carry.
- R11: A dropped sample yields a slot with `out_valid`=0 and `out_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock, one sample slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample slot carries data |
| in_chan | input | 4 | Channel tag of the sample |
| in_sample | input | 10 | Filtered sample value |
| thr_high | input | 10 | Pulse-open threshold (strict greater-than) |
| thr_low | input | 10 | Pulse-close threshold (less-than), clamped to thr_high |
| win_len | input | 4 | Tail length in samples after a pulse closes, 0 to 15 |
| out_valid | output | 1 | Output word is a forwarded sample |
| out_chan | output | 4 | Channel tag of the forwarded sample |
| out_sample | output | 10 | Value of the forwarded sample |
| out_hit | output | 1 | Forwarded sample lies inside the open pulse |

## Verification
Each input passes through four registers: input capture, threshold compare, state update and output. Every result is therefore due exactly four cycles after its input is driven. The bench drives on the falling edge and files the expected word into a slot four steps ahead. It then compares each output against the slot that comes due on that falling edge, so valid, tag, value and flag are all checked in the one cycle they are due. Thresholds and tail length change only after an idle drain of six cycles, so no sample in flight sees a mixed configuration.

// File: rtl/hf_pkg.sv
package hf_pkg;
  localparam int HF_SAMPLE_W = 10;
  localparam int HF_CHANS    = 16;
  localparam int HF_GROUPS   = 4;
  localparam int HF_WIN_W    = 4;

  typedef enum logic [2:0] {
    DEC_DROP  = 3'd0,
    DEC_START = 3'd1,
    DEC_HOLD  = 3'd2,
    DEC_STOP  = 3'd3,
    DEC_TAIL  = 3'd4
  } hf_dec_e;
endpackage

// File: rtl/hf_compare.sv
module hf_compare #(
  parameter int SAMPLE_W = hf_pkg::HF_SAMPLE_W,
  parameter int CHANS    = hf_pkg::HF_CHANS,
  localparam int CHAN_W  = $clog2(CHANS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  input  logic [CHAN_W-1:0]   s_chan,
  input  logic [SAMPLE_W-1:0] s_sample,
  input  logic [SAMPLE_W-1:0] thr_high,
  input  logic [SAMPLE_W-1:0] thr_low,
  output logic                c_valid,
  output logic [CHAN_W-1:0]   c_chan,
  output logic [SAMPLE_W-1:0] c_sample,
  output logic                c_above_hi,
  output logic                c_below_lo
);
  logic [SAMPLE_W-1:0] lo_eff;
  logic                above_nxt;
  logic                below_nxt;

  always_comb begin
    lo_eff    = (thr_low > thr_high) ? thr_high : thr_low;
    above_nxt = s_sample > thr_high;
    below_nxt = s_sample < lo_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_valid    <= 1'b0;
      c_chan     <= '0;
      c_sample   <= '0;
      c_above_hi <= 1'b0;
      c_below_lo <= 1'b0;
    end else begin
      c_valid <= s_valid;
      if (s_valid) begin
        c_chan     <= s_chan;
        c_sample   <= s_sample;
        c_above_hi <= above_nxt;
        c_below_lo <= below_nxt;
      end
    end
  end

  // R9: the clamped band never lets a sample be both above high and below low
  assert_band_disjoint_R9: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid |-> !(c_above_hi && c_below_lo));
endmodule

// File: rtl/hf_chan_state.sv
module hf_chan_state #(
  parameter int SAMPLE_W = hf_pkg::HF_SAMPLE_W,
  parameter int CHANS    = hf_pkg::HF_CHANS,
  parameter int GROUPS   = hf_pkg::HF_GROUPS,
  parameter int WIN_W    = hf_pkg::HF_WIN_W,
  localparam int CHAN_W  = $clog2(CHANS),
  localparam int LANES   = CHANS / GROUPS,
  localparam int LANE_W  = $clog2(LANES),
  localparam int GROUP_W = $clog2(GROUPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                c_valid,
  input  logic [CHAN_W-1:0]   c_chan,
  input  logic [SAMPLE_W-1:0] c_sample,
  input  logic                c_above_hi,
  input  logic                c_below_lo,
  input  logic [WIN_W-1:0]    win_len,
  output logic                d_valid,
  output logic [CHAN_W-1:0]   d_chan,
  output logic [SAMPLE_W-1:0] d_sample,
  output logic                d_hit
);
  import hf_pkg::*;

  logic [GROUP_W-1:0]            grp;
  logic [LANE_W-1:0]             lane;
  logic [GROUPS-1:0]             rd_hit;
  logic [GROUPS-1:0][WIN_W-1:0]  rd_cnt;
  logic                          old_hit;
  logic [WIN_W-1:0]              old_cnt;
  hf_dec_e                       dec;
  logic                          nxt_hit;
  logic [WIN_W-1:0]              nxt_cnt;
  logic                          keep;

  assign grp  = c_chan[CHAN_W-1:LANE_W];
  assign lane = c_chan[LANE_W-1:0];

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [LANES-1:0]            lane_hit;
    logic [LANES-1:0][WIN_W-1:0] lane_cnt;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic             hit_q;
      logic [WIN_W-1:0] cnt_q;
      logic             wr_en;
      assign wr_en       = c_valid && (grp == GROUP_W'(g)) && (lane == LANE_W'(l));
      assign lane_hit[l] = hit_q;
      assign lane_cnt[l] = cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hit_q <= 1'b0;
          cnt_q <= '0;
        end else if (wr_en) begin
          hit_q <= nxt_hit;
          cnt_q <= nxt_cnt;
        end
      end
    end
    assign rd_hit[g] = lane_hit[lane];
    assign rd_cnt[g] = lane_cnt[lane];
  end

  always_comb begin
    old_hit = rd_hit[grp];
    old_cnt = rd_cnt[grp];
    if (old_hit)               dec = c_below_lo ? DEC_STOP : DEC_HOLD;
    else if (c_above_hi)       dec = DEC_START;
    else if (old_cnt != '0)    dec = DEC_TAIL;
    else                       dec = DEC_DROP;
    nxt_hit = 1'b0;
    nxt_cnt = old_cnt;
    case (dec)
      DEC_START: begin nxt_hit = 1'b1; nxt_cnt = '0; end
      DEC_HOLD:  begin nxt_hit = 1'b1; nxt_cnt = '0; end
      DEC_STOP:  begin nxt_hit = 1'b0; nxt_cnt = win_len; end
      DEC_TAIL:  begin nxt_hit = 1'b0; nxt_cnt = old_cnt - 1'b1; end
      default:   begin nxt_hit = 1'b0; nxt_cnt = old_cnt; end
    endcase
    keep = (dec != DEC_DROP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_valid  <= 1'b0;
      d_chan   <= '0;
      d_sample <= '0;
      d_hit    <= 1'b0;
    end else begin
      d_valid <= c_valid && keep;
      if (c_valid) begin
        d_chan   <= c_chan;
        d_sample <= c_sample;
        d_hit    <= nxt_hit;
      end
    end
  end

  // R3: a crossing above the high threshold on an idle channel is forwarded as a hit
  assert_open_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && !old_hit && c_above_hi) |=> (d_valid && d_hit));
  // R5: a close is forwarded without the hit flag
  assert_close_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && old_hit && c_below_lo) |=> (d_valid && !d_hit));
  // R6: an idle channel with an exhausted tail drops its sample
  assert_tail_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && !old_hit && !c_above_hi && old_cnt == '0) |=> !d_valid);
  // R7: an open pulse never carries a pending tail count
  assert_open_no_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (c_valid && old_hit) |-> (old_cnt == '0));
endmodule

// File: rtl/hf_top.sv
module hf_top #(
  parameter int SAMPLE_W = hf_pkg::HF_SAMPLE_W,
  parameter int CHANS    = hf_pkg::HF_CHANS,
  parameter int GROUPS   = hf_pkg::HF_GROUPS,
  parameter int WIN_W    = hf_pkg::HF_WIN_W,
  localparam int CHAN_W  = $clog2(CHANS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [CHAN_W-1:0]   in_chan,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [SAMPLE_W-1:0] thr_high,
  input  logic [SAMPLE_W-1:0] thr_low,
  input  logic [WIN_W-1:0]    win_len,
  output logic                out_valid,
  output logic [CHAN_W-1:0]   out_chan,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic                out_hit
);
  logic                s_valid;
  logic [CHAN_W-1:0]   s_chan;
  logic [SAMPLE_W-1:0] s_sample;
  logic                c_valid, c_above_hi, c_below_lo;
  logic [CHAN_W-1:0]   c_chan;
  logic [SAMPLE_W-1:0] c_sample;
  logic                d_valid, d_hit;
  logic [CHAN_W-1:0]   d_chan;
  logic [SAMPLE_W-1:0] d_sample;

  // input capture stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid  <= 1'b0;
      s_chan   <= '0;
      s_sample <= '0;
    end else begin
      s_valid <= in_valid;
      if (in_valid) begin
        s_chan   <= in_chan;
        s_sample <= in_sample;
      end
    end
  end

  hf_compare #(.SAMPLE_W(SAMPLE_W), .CHANS(CHANS)) u_cmp (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_chan(s_chan), .s_sample(s_sample),
    .thr_high(thr_high), .thr_low(thr_low),
    .c_valid(c_valid), .c_chan(c_chan), .c_sample(c_sample),
    .c_above_hi(c_above_hi), .c_below_lo(c_below_lo)
  );

  hf_chan_state #(.SAMPLE_W(SAMPLE_W), .CHANS(CHANS), .GROUPS(GROUPS), .WIN_W(WIN_W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .c_valid(c_valid), .c_chan(c_chan), .c_sample(c_sample),
    .c_above_hi(c_above_hi), .c_below_lo(c_below_lo), .win_len(win_len),
    .d_valid(d_valid), .d_chan(d_chan), .d_sample(d_sample), .d_hit(d_hit)
  );

  // output stage onto the single merged stream
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_chan   <= '0;
      out_sample <= '0;
      out_hit    <= 1'b0;
    end else begin
      out_valid <= d_valid;
      out_hit   <= d_valid && d_hit;
      if (d_valid) begin
        out_chan   <= d_chan;
        out_sample <= d_sample;
      end
    end
  end

  // R2: forwarded word carries the tag and value presented four cycles earlier
  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_chan == $past(in_chan, 4) && out_sample == $past(in_sample, 4)));
  // R10: an output word needs a valid input slot four cycles earlier
  assert_needs_input_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4));
  // R11: the hit flag is never raised on a dropped slot
  assert_flag_in_slot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_valid);
endmodule

// File: tb/hf_top_tb.sv
module hf_top_tb;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic [3:0] in_chan;
  logic [9:0] in_sample;
  logic [9:0] thr_high, thr_low;
  logic [3:0] win_len;
  logic       out_valid, out_hit;
  logic [3:0] out_chan;
  logic [9:0] out_sample;

  always #10 clk = ~clk;

  hf_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .in_sample(in_sample), .thr_high(thr_high), .thr_low(thr_low),
    .win_len(win_len), .out_valid(out_valid), .out_chan(out_chan),
    .out_sample(out_sample), .out_hit(out_hit)
  );

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  bit    done     = 0;
  string ptag     = "R1";

  bit    m_hit [16];
  int    m_cnt [16];
  bit    e_v   [8];
  bit    e_h   [8];
  int    e_ch  [8];
  int    e_s   [8];
  string e_tag [8];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) %s: actual=%0d expected=%0d at step %0d", tag, ptag, what, act, exp, cyc);
    end
  endtask

  function automatic int lo_eff();
    return (thr_low > thr_high) ? int'(thr_high) : int'(thr_low);
  endfunction

  // reference model: decide and update one channel
  task automatic model(input bit v, input int ch, input int s, output bit ev, output bit eh, output string tag);
    bit oh, start, stop;
    int oc;
    if (!v) begin
      ev = 0; eh = 0; tag = "R10";
      return;
    end
    oh = m_hit[ch]; oc = m_cnt[ch];
    start = !oh && (s > int'(thr_high));
    stop  = oh && (s < lo_eff());
    ev = oh || start || (oc != 0);
    eh = start || (oh && !stop);
    if (start)      tag = (oc != 0) ? "R7" : "R3";
    else if (oh)    tag = stop ? "R5" : "R4";
    else if (oc != 0) tag = "R6";
    else            tag = "R11";
    if (start)      begin m_hit[ch] = 1; m_cnt[ch] = 0; end
    else if (stop)  begin m_hit[ch] = 0; m_cnt[ch] = int'(win_len); end
    else if (!oh && oc != 0) m_cnt[ch] = oc - 1;
  endtask

  task automatic step(input bit v, input int ch, input int s);
    int k = cyc % 8;
    int w = (cyc + LAT) % 8;
    bit ev, eh;
    string tag;
    chk(out_valid == e_v[k], e_tag[k], "out_valid", int'(out_valid), int'(e_v[k]));
    if (e_v[k]) begin
      chk(out_chan == 4'(e_ch[k]), "R2", "out_chan", int'(out_chan), e_ch[k]);
      chk(out_sample == 10'(e_s[k]), "R2", "out_sample", int'(out_sample), e_s[k]);
      chk(out_hit == e_h[k], e_tag[k], "out_hit", int'(out_hit), int'(e_h[k]));
    end else begin
      chk(out_hit == 1'b0, "R11", "out_hit on empty slot", int'(out_hit), 0);
    end
    in_valid  = v;
    in_chan   = 4'(ch);
    in_sample = 10'(s);
    model(v, ch, s, ev, eh, tag);
    e_v[w] = ev; e_h[w] = eh; e_ch[w] = ch; e_s[w] = s; e_tag[w] = tag;
    @(negedge clk);
    cyc++;
  endtask

  task automatic drain();
    repeat (6) step(0, 0, 0);
  endtask

  function automatic int rnd_sample();
    case ($urandom_range(0, 3))
      0: return int'($urandom_range(0, 1023));
      1: return int'($urandom_range(int'(thr_high), 1023));
      2: return int'($urandom_range(250, 550));
      default: return int'($urandom_range(0, 100));
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: run did not finish, actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin m_hit[i] = 0; m_cnt[i] = 0; end
    for (int i = 0; i < 8; i++) begin
      e_v[i] = 0; e_h[i] = 0; e_ch[i] = 0; e_s[i] = 0; e_tag[i] = "R1";
    end
    rst_n = 0; in_valid = 0; in_chan = 0; in_sample = 0;
    thr_high = 10'd500; thr_low = 10'd300; win_len = 4'd2;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);

    // R1: fresh channels drop sub-threshold samples; R3 equality does not open
    ptag = "R1";
    step(1, 3, 100); step(1, 3, 500);
    // R3 open, R4 hold at low edge, R5 close, R6 tail of 2 then drop
    ptag = "R3";
    step(1, 3, 501); step(1, 3, 300); step(1, 3, 299);
    ptag = "R6";
    step(1, 3, 10); step(1, 3, 10); step(1, 3, 10);
    // R7 retrigger in tail, then reload at next close
    ptag = "R7";
    step(1, 3, 600); step(1, 3, 100); step(1, 3, 20); step(1, 3, 700);
    step(1, 3, 50); step(1, 3, 5); step(1, 3, 5); step(1, 3, 5);
    // R8 interleaved channels, back-to-back same channel
    ptag = "R8";
    step(1, 1, 900); step(1, 2, 20); step(1, 1, 400); step(1, 2, 499);
    step(1, 1, 100); step(1, 1, 100); step(1, 2, 30); step(1, 1, 100); step(1, 1, 100);
    // R10 invalid slots with loud data leave state alone
    ptag = "R10";
    step(0, 5, 1023); step(0, 5, 1023); step(1, 5, 0);
    step(1, 5, 800); step(0, 5, 0); step(0, 5, 0); step(1, 5, 450);
    step(1, 5, 0);
    drain();
    // R6 with a zero tail
    ptag = "R6";
    win_len = 4'd0;
    step(1, 7, 1000); step(1, 7, 0); step(1, 7, 0); step(1, 7, 900);
    drain();
    // R9 low programmed above high
    ptag = "R9";
    thr_high = 10'd400; thr_low = 10'd800; win_len = 4'd1;
    step(1, 9, 401); step(1, 9, 400); step(1, 9, 450); step(1, 9, 399);
    step(1, 9, 0); step(1, 9, 0);
    drain();
    // R6 full-length tail of 15
    ptag = "R6";
    thr_high = 10'd500; thr_low = 10'd300; win_len = 4'd15;
    step(1, 15, 1023); step(1, 15, 0);
    for (int i = 0; i < 16; i++) step(1, 15, 0);
    drain();

    // R8 constrained random interleaving across several configurations
    for (int ph = 0; ph < 6; ph++) begin
      ptag = (ph == 5) ? "R9" : "R8";
      thr_high = 10'($urandom_range(350, 650));
      thr_low  = (ph == 5) ? 10'($urandom_range(700, 1000)) : 10'($urandom_range(150, 340));
      win_len  = (ph == 0) ? 4'd0 : (ph == 1) ? 4'd15 : 4'($urandom_range(0, 15));
      for (int i = 0; i < 1500; i++) begin
        int ch = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 15)) : (i % 16);
        step($urandom_range(0, 9) != 0, ch, rnd_sample());
      end
      drain();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule